// File: doc/BRIEF.md
# Memory Wait-State and Bank-Select Controller

This block sits between a 16-bit processor's external memory strobe and two static RAM banks. On every clock it looks at the active-low memory enable from the processor and the three most significant address bits. From them it produces one active-low chip enable for each RAM bank. Two map straps decide which bank answers each 8 KB block of the address space.

Two wait-select straps set how long an external access lasts: 2, 3, 4 or 5 clock cycles. The block holds the processor off with a wait output until that many cycles have passed. It also exposes a thermometer of tap outputs, one for each intermediate wait count, which can be used as alternative wait sources.

A fitted strap reads as logic 0. Straps are expected to be static while the block runs. All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `memwait_ctrl`

## Requirements
- R1: With wait straps `wsel_n` = 2'b00 (both fitted, 2-cycle access), `mem_wait` is never asserted.
- R2: With `wsel_n` = 2'b01 (second strap fitted, 3-cycle access), `mem_wait` is high for exactly 1 cycle per access.
- R3: With `wsel_n` = 2'b10 (first strap fitted, 4-cycle access), `mem_wait` is high for exactly 2 cycles per access.
- R4: With `wsel_n` = 2'b11 (no strap, 5-cycle access), `mem_wait` is high for exactly 3 cycles per access.
- R5: An access starts at the clock edge that samples `mem_ce_n` low after sampling it high. If the wait count W = N-2 is non-zero, `mem_wait` is high in the cycle after that edge and falls W cycles later. It then stays low for the remainder of that access.
- R6: If `mem_ce_n` is sampled high for a single cycle and then low again, the wait count restarts from zero.
- R7: `wait_tap[j]` (j = 0, 1, 2) is high when `mem_ce_n` is low and at least j+1 cycles have passed since the access started; it is independent of `wsel_n`, and the taps always form a thermometer code.
- R8: Map code `map_n` = 2'b00 selects bank 0 (`bank_ce_n[0]` low) for `addr_hi` 0..3 and bank 1 (`bank_ce_n[1]` low) for `addr_hi` 4..7.
- R9: Map code 2'b01 selects bank 0 for all eight blocks.
- R10: Map code 2'b10 selects bank 1 for all eight blocks.
- R11: Map code 2'b11 swaps the halves: bank 1 for `addr_hi` 0..3 and bank 0 for 4..7.
- R12: At most one bank enable is low at any time. A cycle that samples `mem_ce_n` high is followed by both bank enables high and by `mem_wait` and all taps low.
- R13: While `rst` is high, both bank enables are high and `mem_wait` and all taps are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ce_n | input | 1 | Active-low memory enable from the processor |
| addr_hi | input | 3 | Address bits 15..13 (8 KB block index) |
| wsel_n | input | 2 | Wait-select straps, fitted = 0 |
| map_n | input | 2 | Block-map straps, fitted = 0 |
| bank_ce_n | output | 2 | Active-low chip enables, bit b for bank b |
| wait_tap | output | 3 | Intermediate wait-count taps, bit j = j+1 waits elapsed |
| mem_wait | output | 1 | Selected wait to the processor's memory-wait input |

## Verification
The properties assume that the wait straps do not change during an access. A run of wait cycles is measured against the strap value of the current cycle, so a strap change in mid-access would break that property. The bench therefore moves `wsel_n` and `map_n` only while `mem_ce_n` is high, and holds `mem_ce_n` high throughout reset. It does this so that the first access begins with a clean high-to-low transition. Address bits may change during an access. The bench does this, and the bank decode follows the new address one cycle later.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  // Number of wait cycles (access length minus two) for a strap code
  function automatic logic [1:0] strap_wait(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  typedef enum logic [1:0] {
    MAP_SPLIT = 2'b00,
    MAP_LOW   = 2'b01,
    MAP_HIGH  = 2'b10,
    MAP_SWAP  = 2'b11
  } map_code_e;

endpackage

// File: rtl/memwait_strap_dec.sv
module memwait_strap_dec
  import memwait_pkg::*;
#(
  parameter int BLK_BITS = 3,
  parameter int CNT_W    = 2,
  localparam int NBLK    = 1 << BLK_BITS
) (
  input  logic [1:0]       wsel_n,
  input  logic [1:0]       map_n,
  output logic [CNT_W-1:0] wait_len,
  output logic [NBLK-1:0]  blk_bank
);

  localparam int HALF = NBLK / 2;

  always_comb wait_len = CNT_W'(strap_wait(wsel_n));

  // one bank-select bit per 8 KB block
  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam bit UPPER = (k >= HALF);
    always_comb begin
      case (map_code_e'(map_n))
        MAP_SPLIT: blk_bank[k] = UPPER;
        MAP_LOW:   blk_bank[k] = 1'b0;
        MAP_HIGH:  blk_bank[k] = 1'b1;
        default:   blk_bank[k] = !UPPER;
      endcase
    end
  end

endmodule

// File: rtl/memwait_bank_dec.sv
module memwait_bank_dec #(
  parameter int BLK_BITS = 3,
  localparam int NBLK    = 1 << BLK_BITS,
  localparam int NBANK   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mem_ce_n,
  input  logic [BLK_BITS-1:0] addr_hi,
  input  logic [NBLK-1:0]     blk_bank,
  output logic [NBANK-1:0]    bank_ce_n
);

  logic sel;
  always_comb sel = blk_bank[addr_hi];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) bank_ce_n[b] <= 1'b1;
      else     bank_ce_n[b] <= !(!mem_ce_n && (sel == b[0]));
    end
  end

endmodule

// File: rtl/memwait_wait_cnt.sv
module memwait_wait_cnt #(
  parameter int MAX_WAIT = 3,
  parameter int CNT_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mem_ce_n,
  input  logic [CNT_W-1:0]    wait_len,
  output logic                wait_o,
  output logic [MAX_WAIT-1:0] taps
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_WAIT);

  logic             ce_q;
  logic [CNT_W-1:0] elap, elap_nx;

  // elapsed cycles since the access began, restarting on a high-to-low edge
  always_comb begin
    if (mem_ce_n || ce_q) elap_nx = '0;
    else if (elap == SAT) elap_nx = elap;
    else                  elap_nx = elap + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      elap   <= '0;
      wait_o <= 1'b0;
    end else begin
      ce_q   <= mem_ce_n;
      elap   <= elap_nx;
      wait_o <= !mem_ce_n && (elap_nx < wait_len);
    end
  end

  for (genvar j = 0; j < MAX_WAIT; j++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) taps[j] <= 1'b0;
      else     taps[j] <= !mem_ce_n && (elap_nx > CNT_W'(j));
    end
  end

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl #(
  parameter int BLK_BITS = 3,
  parameter int MAX_WAIT = 3,
  localparam int CNT_W   = $clog2(MAX_WAIT + 1),
  localparam int NBLK    = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mem_ce_n,
  input  logic [BLK_BITS-1:0] addr_hi,
  input  logic [1:0]          wsel_n,
  input  logic [1:0]          map_n,
  output logic [1:0]          bank_ce_n,
  output logic [MAX_WAIT-1:0] wait_tap,
  output logic                mem_wait
);

  logic [CNT_W-1:0] wait_len;
  logic [NBLK-1:0]  blk_bank;

  memwait_strap_dec #(.BLK_BITS(BLK_BITS), .CNT_W(CNT_W)) u_strap (
    .wsel_n   (wsel_n),
    .map_n    (map_n),
    .wait_len (wait_len),
    .blk_bank (blk_bank)
  );

  memwait_bank_dec #(.BLK_BITS(BLK_BITS)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .mem_ce_n  (mem_ce_n),
    .addr_hi   (addr_hi),
    .blk_bank  (blk_bank),
    .bank_ce_n (bank_ce_n)
  );

  memwait_wait_cnt #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .mem_ce_n (mem_ce_n),
    .wait_len (wait_len),
    .wait_o   (mem_wait),
    .taps     (wait_tap)
  );

endmodule

// File: rtl/memwait_ctrl_chk.sv
module memwait_ctrl_chk
  import memwait_pkg::*;
#(
  parameter int MAX_WAIT = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                mem_ce_n,
  input logic [1:0]          wsel_n,
  input logic [1:0]          bank_ce_n,
  input logic [MAX_WAIT-1:0] wait_tap,
  input logic                mem_wait
);

  // consecutive cycles of wait seen before the current one
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (mem_wait) run <= (run == 8'hFF) ? run : run + 8'd1;
    else               run <= '0;
  end

  // R12
  bank_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bank_ce_n));

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |=> (&bank_ce_n && !mem_wait && wait_tap == '0));

  // R1
  no_wait_short_chk: assert property (@(posedge clk) disable iff (rst)
    (wsel_n == 2'b00) |=> !mem_wait);

  // R5
  wait_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_ce_n) && wsel_n != 2'b00) |=> mem_wait);

  // R4
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wait |-> (run < 8'(strap_wait(wsel_n))));

  // R7
  tap_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |=> (wait_tap == '0));

  // R7
  tap_thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_tap[2] |-> wait_tap[1]) and (wait_tap[1] |-> wait_tap[0]));

endmodule

bind memwait_ctrl memwait_ctrl_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_ce_n  (mem_ce_n),
  .wsel_n    (wsel_n),
  .bank_ce_n (bank_ce_n),
  .wait_tap  (wait_tap),
  .mem_wait  (mem_wait)
);

// File: tb/sim_memwait_ctrl.sv
module sim_memwait_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_ce_n = 1'b1;
  logic [2:0] addr_hi = 3'd0;
  logic [1:0] wsel_n = 2'b00;
  logic [1:0] map_n = 2'b00;
  logic [1:0] bank_ce_n;
  logic [2:0] wait_tap;
  logic       mem_wait;

  always #2 clk = ~clk;  // 250 MHz

  memwait_ctrl u0 (
    .clk(clk), .rst(rst), .mem_ce_n(mem_ce_n), .addr_hi(addr_hi),
    .wsel_n(wsel_n), .map_n(map_n), .bank_ce_n(bank_ce_n),
    .wait_tap(wait_tap), .mem_wait(mem_wait)
  );

  typedef struct {
    int         due;
    logic [1:0] bce;
    logic [2:0] tp;
    logic       w;
    int         tag_w;
    int         tag_b;
    int         tag_t;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   m_e = 0;
  bit   m_pq = 1'b1;
  int   force_tag = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc++;

  // driver step: applies inputs, pushes the outputs due after the next edge
  task automatic step(input bit r, input bit ce, input logic [2:0] a);
    exp_t e;
    bit   start, bank;
    int   en, wl;
    @(negedge clk);
    rst = r; mem_ce_n = ce; addr_hi = a;
    e.due = cyc + 1;
    if (r) begin
      m_pq = 1'b1; m_e = 0;
      e.bce = 2'b11; e.tp = 3'b000; e.w = 1'b0;
      e.tag_w = 13; e.tag_b = 13; e.tag_t = 13;  // R13
    end else begin
      start = !ce && m_pq;
      en = (ce || start) ? 0 : ((m_e + 1 > 3) ? 3 : m_e + 1);
      // R1..R4 wait counts: 00->0, 01->1, 10->2, 11->3
      case (wsel_n)
        2'b00: wl = 0;
        2'b01: wl = 1;
        2'b10: wl = 2;
        default: wl = 3;
      endcase
      e.w = !ce && (en < wl);
      for (int j = 0; j < 3; j++) e.tp[j] = !ce && (en > j);
      // R8..R11 block maps
      case (map_n)
        2'b00: bank = a[2];
        2'b01: bank = 1'b0;
        2'b10: bank = 1'b1;
        default: bank = !a[2];
      endcase
      e.bce = ce ? 2'b11 : (bank ? 2'b01 : 2'b10);
      e.tag_w = (force_tag != 0) ? force_tag : (ce ? 12 : wl + 1);
      e.tag_b = ce ? 12 : 8 + int'(map_n);
      e.tag_t = ce ? 12 : 7;
      m_pq = ce; m_e = en;
    end
    q.push_back(e);
  endtask

  task automatic access(input logic [2:0] a, input int hold);
    for (int i = 0; i < hold; i++) step(1'b0, 1'b0, a);
    step(1'b0, 1'b1, a);
  endtask

  // monitor: compares the outputs against items whose edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks += 3;
      if (mem_wait !== e.w) begin
        fails++;
        $display("FAIL R%0d mem_wait actual=%b expected=%b cyc=%0d", e.tag_w, mem_wait, e.w, cyc);
      end
      if (bank_ce_n !== e.bce) begin
        fails++;
        $display("FAIL R%0d bank_ce_n actual=%b expected=%b cyc=%0d", e.tag_b, bank_ce_n, e.bce, cyc);
      end
      if (wait_tap !== e.tp) begin
        fails++;
        $display("FAIL R%0d wait_tap actual=%b expected=%b cyc=%0d", e.tag_t, wait_tap, e.tp, cyc);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R13: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'd0);
    step(1'b0, 1'b1, 3'd0);
    // R1, R2, R3, R4, R5, R7 with map R8
    for (int ws = 0; ws < 4; ws++) begin
      wsel_n = 2'(ws);
      access(3'(ws * 2 + 1), 6);
      step(1'b0, 1'b1, 3'd0);
    end
    // R8, R9, R10, R11: every block under every map code
    wsel_n = 2'b01;
    for (int m = 0; m < 4; m++) begin
      map_n = 2'(m);
      for (int a = 0; a < 8; a++) access(3'(a), 2);
    end
    // address moving mid-access
    map_n = 2'b00; wsel_n = 2'b10;
    step(1'b0, 1'b0, 3'd1); step(1'b0, 1'b0, 3'd6); step(1'b0, 1'b0, 3'd3);
    step(1'b0, 1'b1, 3'd3);
    // R6: one high sample restarts the count
    wsel_n = 2'b11; force_tag = 6;
    access(3'd2, 2);
    access(3'd5, 5);
    access(3'd7, 1);
    access(3'd0, 4);
    force_tag = 0;
    // R12: back-to-back short accesses with one idle cycle
    wsel_n = 2'b00;
    for (int i = 0; i < 4; i++) access(3'(i * 3), 1);
    // R13: reset during an access
    wsel_n = 2'b11;
    step(1'b0, 1'b0, 3'd4); step(1'b0, 1'b0, 3'd4);
    step(1'b1, 1'b1, 3'd4); step(1'b1, 1'b1, 3'd4);
    step(1'b0, 1'b1, 3'd4);
    access(3'd4, 5);
    repeat (3) step(1'b0, 1'b1, 3'd0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule